// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the word addresses for one DMA channel that moves a two-dimensional frame. A frame is a set of lines. Each line has a programmable number of active words, and a stride sets the distance in words from one line start to the next. The gap between lines is whatever the stride adds beyond the active words. The block issues one word request per cycle under a valid/ready handshake. It also shows its live word address at all times, so software can work out how far a running transfer has progressed.

A line length of zero selects a ring-buffer mode. In this mode the block sweeps a region of stride×(line count+1) words, returns to the region start after the last word, and keeps going until the channel is stopped or looping is disabled. Each pass raises one event at the end of the first half of the region and another at the end of the second half. Data movement, bus protocol and arbitration between channels are handled elsewhere.

Top module: `dma2d_addr_seq`

## Requirements
- R1: After reset the block is idle. busy_o, req_valid_o, done_o, half_o, full_o, req_dir_o and req_burst_o are low, and cur_addr_o is zero.
- R2: While the block is idle and stop_i is low, start_i loads the programmed parameters. It is taken only when line_len_i is nonzero or loop_en_i is high. From the next cycle busy_o is high and cur_addr_o equals base_addr_i, which is a word address (a byte address shifted right by two).
- R3: A word is taken only in a cycle where req_valid_o and req_ready_i are both high. req_valid_o is low while the block is idle. While a request waits without ready, req_addr_o holds its value.
- R4: In frame mode (line_len_i nonzero), word j of line k goes out at base + k×stride + j. There are line_cnt_i+1 lines of line_len_i words each, issued in ascending order. req_addr_o always equals cur_addr_o.
- R5: In frame mode, done_o pulses for exactly one cycle. That cycle is the one after the final word of the last line is taken, and busy_o is already low in it.
- R6: In loop mode (line_len_i zero), word i of a pass goes out at base + i, for i from 0 to stride×(line count+1)−1. After the last word the address returns to base and the next pass begins.
- R7: In loop mode, with region size N, half_o pulses for one cycle after word floor(N/2)−1 is taken. full_o pulses for one cycle after word N−1 is taken. Both repeat on every pass, and loop mode never raises done_o.
- R8: While loop mode runs with loop_en_i low, req_valid_o is low. The block is idle in the next cycle, with no done_o. A start with line_len_i zero while loop_en_i is low is ignored.
- R9: stop_i forces req_valid_o low in the same cycle. The block is idle in the next cycle and done_o is not raised. stop_i beats a start in the same cycle, and it also beats the final handshake of a frame.
- R10: Control word bit 4 (four-word burst mode) and bit 5 (transfer direction) are captured at start. They drive req_burst_o and req_dir_o and hold until the next accepted start.
- R11: A start_i pulse while busy is ignored, and the running sequence continues unchanged.
- R12: After a frame completes, cur_addr_o holds the final word's address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| stop_i | input | 1 | Abort, returns to idle |
| loop_en_i | input | 1 | Keep loop mode running |
| ctrl_i | input | CTW (8) | Control word: bit 4 burst, bit 5 direction |
| base_addr_i | input | AW (32) | Start word address |
| line_len_i | input | LW (16) | Words per line; zero selects loop mode |
| line_cnt_i | input | CW (16) | Lines per frame minus one |
| stride_i | input | LW (16) | Words from one line start to the next |
| req_ready_i | input | 1 | Consumer takes the current word |
| req_valid_o | output | 1 | Word request pending |
| req_addr_o | output | AW (32) | Word address of the pending request |
| req_dir_o | output | 1 | Captured direction bit |
| req_burst_o | output | 1 | Captured burst-mode bit |
| cur_addr_o | output | AW (32) | Live word address |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Frame complete pulse |
| half_o | output | 1 | Loop first-half event |
| full_o | output | 1 | Loop second-half event |

## Verification
Two things can fall in the same cycle: an abort and the handshake of a frame's final word. The bench provokes this by holding ready high and raising stop_i in exactly the cycle the reference model marks as the last word. It then expects req_valid_o low in that cycle, idle with no done_o in the next, and the address left unadvanced. The same-cycle start and stop while idle is provoked too. A start pulse that arrives in the middle of a run is also tested, and it must leave the address stream untouched.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_e;
  localparam int CTRL_BURST_BIT = 4;
  localparam int CTRL_DIR_BIT   = 5;
endpackage

// File: rtl/dma2d_cnt.sv
module dma2d_cnt #(
  parameter int LW = 16,
  parameter int CW = 16,
  localparam int RW = LW + CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [LW-1:0] len_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [LW-1:0] stride_i,
  output logic          loop_o,
  output logic          eol_o,
  output logic          last_line_o,
  output logic          half_hit_o,
  output logic          region_end_o
);
  logic [LW-1:0] len_q, col_q;
  logic [CW-1:0] cnt_q, row_q;
  logic [RW-1:0] region_q, idx_q;
  logic [RW-1:0] half_w;

  assign half_w       = region_q >> 1;
  assign loop_o       = (len_q == '0);
  assign eol_o        = (col_q == len_q - LW'(1));
  assign last_line_o  = (row_q == cnt_q);
  assign region_end_o = (idx_q == region_q - RW'(1));
  assign half_hit_o   = (half_w != '0) && (idx_q == half_w - RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      cnt_q    <= '0;
      region_q <= '0;
      col_q    <= '0;
      row_q    <= '0;
      idx_q    <= '0;
    end else if (load_i) begin
      len_q    <= len_i;
      cnt_q    <= cnt_i;
      region_q <= RW'(stride_i) * (RW'(cnt_i) + RW'(1));
      col_q    <= '0;
      row_q    <= '0;
      idx_q    <= '0;
    end else if (adv_i) begin
      idx_q <= region_end_o ? '0 : idx_q + RW'(1);
      if (eol_o) begin
        col_q <= '0;
        row_q <= row_q + CW'(1);
      end else begin
        col_q <= col_q + LW'(1);
      end
    end
  end

  // frame column never passes the programmed line length
  p_col_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_o) |-> (col_q < len_q));
  // loop index stays inside the region
  p_idx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_o && region_q != '0) |-> (idx_q < region_q));
endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          loop_i,
  input  logic          eol_i,
  input  logic          last_line_i,
  input  logic          region_end_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] stride_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] base_q, ls_q, cur_q, next_ls;
  logic [LW-1:0] stride_q;

  assign next_ls = ls_q + AW'(stride_q);
  assign cur_o   = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      ls_q     <= '0;
      cur_q    <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      base_q   <= base_i;
      ls_q     <= base_i;
      cur_q    <= base_i;
      stride_q <= stride_i;
    end else if (adv_i) begin
      if (loop_i && region_end_i) begin
        cur_q <= base_q;
      end else if (!loop_i && eol_i && !last_line_i) begin
        ls_q  <= next_ls;
        cur_q <= next_ls;
      end else begin
        cur_q <= cur_q + AW'(1);
      end
    end
  end

  p_wrap_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && loop_i && region_end_i) |=> (cur_q == base_q));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(cur_q));
endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
  import dma2d_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int CW  = 16,
  parameter int CTW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           stop_i,
  input  logic           loop_en_i,
  input  logic [CTW-1:0] ctrl_i,
  input  logic [AW-1:0]  base_addr_i,
  input  logic [LW-1:0]  line_len_i,
  input  logic [CW-1:0]  line_cnt_i,
  input  logic [LW-1:0]  stride_i,
  input  logic           req_ready_i,
  output logic           req_valid_o,
  output logic [AW-1:0]  req_addr_o,
  output logic           req_dir_o,
  output logic           req_burst_o,
  output logic [AW-1:0]  cur_addr_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           half_o,
  output logic           full_o
);
  seq_st_e st_q;
  logic loop_w, eol_w, last_w, half_w, rend_w;
  logic halt, go, accept, fin;
  logic dir_q, burst_q, done_q, half_q, full_q;
  logic [AW-1:0] cur_w;

  assign halt   = stop_i | (loop_w & ~loop_en_i);
  assign go     = (st_q == ST_IDLE) & start_i & ~stop_i
                & ((line_len_i != '0) | loop_en_i);
  assign req_valid_o = (st_q == ST_RUN) & ~halt;
  assign accept = req_valid_o & req_ready_i;
  assign fin    = accept & ~loop_w & eol_w & last_w;

  dma2d_cnt #(.LW(LW), .CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(go), .adv_i(accept),
    .len_i(line_len_i), .cnt_i(line_cnt_i), .stride_i(stride_i),
    .loop_o(loop_w), .eol_o(eol_w), .last_line_o(last_w),
    .half_hit_o(half_w), .region_end_o(rend_w)
  );

  dma2d_addr #(.AW(AW), .LW(LW)) u_addr (
    .clk_i, .rst_ni,
    .load_i(go), .adv_i(accept),
    .loop_i(loop_w), .eol_i(eol_w), .last_line_i(last_w),
    .region_end_i(rend_w),
    .base_i(base_addr_i), .stride_i(stride_i),
    .cur_o(cur_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      done_q <= fin;
      half_q <= accept & loop_w & half_w;
      full_q <= accept & loop_w & rend_w;
      if (go) begin
        st_q    <= ST_RUN;
        dir_q   <= ctrl_i[CTRL_DIR_BIT];
        burst_q <= ctrl_i[CTRL_BURST_BIT];
      end else if (st_q == ST_RUN && (halt || fin)) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign busy_o      = (st_q == ST_RUN);
  assign req_addr_o  = cur_w;
  assign cur_addr_o  = cur_w;
  assign req_dir_o   = dir_q;
  assign req_burst_o = burst_q;
  assign done_o      = done_q;
  assign half_o      = half_q;
  assign full_o      = full_q;

  p_idle_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);
  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> $stable(req_addr_o));
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_evt_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, half_o, full_o}));
  p_loop_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && loop_w && !loop_en_i) |=> (!busy_o && !done_o));
  p_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> (!busy_o && !done_o));
  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(req_dir_o) && $stable(req_burst_o)));
endmodule

// File: tb/dma2d_addr_seq_bench.sv
module dma2d_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, loop_en = 1'b0;
  logic [7:0]  ctrl = '0;
  logic [31:0] base = '0;
  logic [15:0] len = '0, cnt = '0, stride = '0;
  logic        ready = 1'b0;
  logic        valid, dir, burst, busy, done, half, full;
  logic [31:0] raddr, caddr;

  always #10 clk = ~clk;

  dma2d_addr_seq u_dma2d_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .loop_en_i(loop_en), .ctrl_i(ctrl), .base_addr_i(base),
    .line_len_i(len), .line_cnt_i(cnt), .stride_i(stride),
    .req_ready_i(ready), .req_valid_o(valid), .req_addr_o(raddr),
    .req_dir_o(dir), .req_burst_o(burst), .cur_addr_o(caddr),
    .busy_o(busy), .done_o(done), .half_o(half), .full_o(full)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit rdy_rand = 1'b0, rdy_fix = 1'b1;

  // reference model state
  bit m_busy = 0, m_loop = 0, m_done = 0, m_half = 0, m_full = 0, m_dir = 0, m_burst = 0;
  int m_i = 0, m_total = 0, m_r = 0, m_len = 0, m_stride = 0;
  logic [31:0] m_base = '0, m_cur = '0;

  function automatic logic [31:0] f_addr(int i);
    return m_base + 32'((i / m_len) * m_stride + (i % m_len));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    m_done = 0; m_half = 0; m_full = 0;
    if (!rst_n) begin
      m_busy = 0; m_loop = 0; m_dir = 0; m_burst = 0; m_cur = '0; m_i = 0;
    end else if (m_busy) begin
      if (stop || (m_loop && !loop_en)) m_busy = 0;
      else if (ready) begin
        if (!m_loop) begin
          if (m_i == m_total - 1) begin
            m_cur = f_addr(m_i) + 32'd1; m_busy = 0; m_done = 1;
          end else begin
            m_i++; m_cur = f_addr(m_i);
          end
        end else begin
          if (m_r / 2 > 0 && m_i == m_r / 2 - 1) m_half = 1;
          if (m_i == m_r - 1) begin m_full = 1; m_i = 0; end
          else m_i++;
          m_cur = m_base + 32'(m_i);
        end
      end
    end else if (start && !stop && (len != 0 || loop_en)) begin
      m_busy = 1; m_loop = (len == 0); m_len = int'(len); m_stride = int'(stride);
      m_total = int'(len) * (int'(cnt) + 1); m_r = int'(stride) * (int'(cnt) + 1);
      m_base = base; m_cur = base; m_i = 0;
      m_dir = ctrl[5]; m_burst = ctrl[4];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    chk("R2 busy", 32'(busy), 32'(m_busy));
    chk("R3 valid", 32'(valid), 32'(m_busy && !stop && !(m_loop && !loop_en)));
    chk("R4 req_addr", raddr, m_cur);
    chk("R12 cur_addr", caddr, m_cur);
    chk("R5 done", 32'(done), 32'(m_done));
    chk("R7 half", 32'(half), 32'(m_half));
    chk("R7 full", 32'(full), 32'(m_full));
    chk("R10 dir", 32'(dir), 32'(m_dir));
    chk("R10 burst", 32'(burst), 32'(m_burst));
  end

  always @(negedge clk) ready <= rdy_rand ? 1'($urandom_range(0, 1)) : rdy_fix;

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] b, input int l, input int c, input int s,
                        input logic [7:0] cw);
    base = b; len = 16'(l); cnt = 16'(c); stride = 16'(s); ctrl = cw;
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic wait_idle(int lim);
    for (int k = 0; k < lim && m_busy; k++) tick();
  endtask

  initial begin
    tick(2);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 valid", 32'(valid), 0);
    chk("R1 cur_addr", caddr, 0);
    chk("R1 events", 32'({done, half, full, dir, burst}), 0);
    rst_n = 1'b1; tick();

    // R4 R5 R10 frame, always ready
    launch(32'h100, 3, 2, 5, 8'h10);
    #5 chk("R2 start addr", caddr, 32'h100);
    chk("R10 burst bit4", 32'(burst), 1);
    wait_idle(100); tick();
    chk("R12 end addr", caddr, 32'h100 + 2 * 5 + 3);

    // R3 stall, R11 start during run
    launch(32'h2000, 4, 3, 7, 8'h20);
    tick(2);
    rdy_fix = 1'b0; tick(2);
    begin
      logic [31:0] held;
      held = raddr; tick(3);
      chk("R3 held addr", raddr, held);
    end
    rdy_rand = 1'b1;
    launch(32'h9000, 2, 0, 2, 8'h00); // R11: ignored while busy
    chk("R11 dir kept", 32'(dir), 1);
    wait_idle(400); rdy_rand = 1'b0; rdy_fix = 1'b1; tick();

    // single-word frame
    launch(32'h40, 1, 0, 1, 8'h30);
    wait_idle(10); tick();
    chk("R12 single end", caddr, 32'h41);

    // R9 stop mid-frame
    launch(32'h500, 8, 3, 8, 8'h00);
    tick(5); stop = 1'b1; tick(); stop = 1'b0;
    chk("R9 stopped", 32'(busy), 0);

    // R9 stop on the final handshake
    launch(32'h600, 2, 1, 4, 8'h00);
    for (int k = 0; k < 20 && !(m_busy && m_i == m_total - 1); k++) tick();
    stop = 1'b1; #5 chk("R9 valid gated", 32'(valid), 0);
    tick(); stop = 1'b0; #5;
    chk("R9 no done", 32'(done), 0);
    chk("R9 addr unadvanced", caddr, 32'h605);
    tick();

    // R9 start and stop in the same idle cycle
    stop = 1'b1; launch(32'h700, 2, 0, 2, 8'h00); stop = 1'b0;
    chk("R9 start blocked", 32'(busy), 0);

    // R8 loop start without enable ignored
    launch(32'h800, 0, 1, 4, 8'h00);
    chk("R8 ignored", 32'(busy), 0);

    // R6 R7 loop, region 8, random ready
    loop_en = 1'b1;
    launch(32'h800, 0, 1, 4, 8'h10);
    rdy_rand = 1'b1; tick(60); rdy_rand = 1'b0; rdy_fix = 1'b1;
    for (int k = 0; k < 10 && !full; k++) tick();
    #5 chk("R6 wrapped to base", caddr, 32'h800);
    tick();
    loop_en = 1'b0; tick(); #5;
    chk("R8 loop exit", 32'(busy), 0);
    chk("R8 no done", 32'(done), 0);

    // R7 odd region of 3, then region of 1
    loop_en = 1'b1;
    launch(32'hA00, 0, 0, 3, 8'h00);
    tick(12); stop = 1'b1; tick(); stop = 1'b0;
    launch(32'hB00, 0, 0, 1, 8'h00);
    tick(6); stop = 1'b1; tick(); stop = 1'b0; loop_en = 1'b0;
    tick(3);
    summary();
    $finish;
  end
endmodule